// File: doc/BRIEF.md
# Switching-Mode Flit Forwarding Gate

This block is the output stage of one router port. Arriving flits are queued in a small local buffer. A gate decides when the packet at the front of that buffer may start leaving toward the next router. A credit counter tracks how many flit slots are free in the downstream buffer. It is loaded with the downstream depth at reset, spends one credit for each flit sent, and regains one for each credit pulse returned by the neighbour.

A two-bit run-time mode input selects one of three start rules: store-and-forward, virtual cut-through or wormhole. Each rule compares the local occupancy and the credit count with the packet length carried in the head flit. Once a head flit has left, the port is held by that packet. Its remaining flits then leave one at a time whenever a credit is available, whatever the mode is at that moment, until the tail flit has been sent. The mode only matters when the next head is at the front.

Top module: `pkt_fwd_gate`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the credit count equals CRED_MAX, so a wormhole packet of CRED_MAX flits can be forwarded in full without any credit return.
- R2: With sw_mode 2'b00, or the unused code 2'b11, a head may leave only when the local buffer holds at least L flits and the credit count is at least L.
- R3: With sw_mode 2'b01, a head may leave as soon as the credit count is at least L, however few of its flits have arrived.
- R4: With sw_mode 2'b10, a head may leave whenever at least one credit is held, and the packet advances flit by flit as far as the credits allow.
- R5: The credit count drops by one for each flit sent, rises by one for each cycle with credit_ret high, and never goes below 0 or above CRED_MAX.
- R6: Flit kinds are encoded on in_kind/out_kind as 2'b01 head, 2'b00 body and 2'b10 tail. The head's in_data[LEN_W-1:0] gives L, the total flit count of the packet including head and tail, with L at least 2.
- R7: After a head has left, no other head leaves until that packet's tail has been sent, and flits leave in arrival order.
- R8: While a packet holds the port, each buffered flit with a credit available is forwarded regardless of sw_mode. A mode change affects only the next head.
- R9: A flit is accepted on a cycle with in_valid and in_ready both high. in_ready is 0 while the local buffer holds BUF_DEPTH flits.
- R10: Each flit that leaves the buffer appears on out_valid/out_kind/out_data one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_mode | input | 2 | Start rule: 00 store-and-forward, 01 cut-through, 10 wormhole |
| in_valid | input | 1 | Input flit present |
| in_ready | output | 1 | Local buffer can take a flit |
| in_kind | input | 2 | Input flit kind |
| in_data | input | DATA_W | Input flit payload; length field in a head |
| out_valid | output | 1 | Output flit present |
| out_kind | output | 2 | Output flit kind |
| out_data | output | DATA_W | Output flit payload |
| credit_ret | input | 1 | One downstream buffer slot freed |

## Verification
The assertions assume well-formed input packets. Each packet opens with a head whose length field is at least 2 and at most BUF_DEPTH, then has exactly L-2 body flits and one tail. The downstream neighbour must never return more credits than flits it has received. The bench builds every packet from a single task that derives the kinds from the length, and it issues a credit pulse only for flits it has already observed at the output. The rules for the packet-locked state are therefore checked only under traffic that respects this framing.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        FL_BODY = 2'b00,
        FL_HEAD = 2'b01,
        FL_TAIL = 2'b10
    } flit_kind_e;

    typedef enum logic [1:0] {
        SW_SAF  = 2'b00,
        SW_VCT  = 2'b01,
        SW_WORM = 2'b10
    } sw_mode_e;

    // true when a value of the given count reaches the needed amount
    function automatic logic reaches(input int unsigned have, input int unsigned need);
        return have >= need;
    endfunction

endpackage

// File: rtl/fwd_flit_buf.sv
module fwd_flit_buf
    import fwd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  flit_kind_e        push_kind,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output flit_kind_e        front_kind,
    output logic [DATA_W-1:0] front_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    flit_kind_e        kind_mem [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            kind_mem[wr_ptr] <= push_kind;
            data_mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign front_kind = kind_mem[rd_ptr];
    assign front_data = data_mem[rd_ptr];
    assign count      = cnt_q;
    assign full       = (cnt_q == CNT_W'(DEPTH));
    assign empty      = (cnt_q == '0);

    // R9
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R9
    push_full_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> !push);

endmodule

// File: rtl/fwd_credit_ctr.sv
module fwd_credit_ctr #(
    parameter int CRED_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic give,
    output logic [$clog2(CRED_MAX+1)-1:0] avail
);
    localparam int CR_W = $clog2(CRED_MAX+1);

    logic [CR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= CR_W'(CRED_MAX);
        else     cnt_q <= cnt_q - CR_W'(take) + CR_W'(give);
    end

    assign avail = cnt_q;

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> (cnt_q != '0));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (give && !take) |-> (cnt_q != CR_W'(CRED_MAX)));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !give) |=> (cnt_q == $past(cnt_q) - CR_W'(1)));

endmodule

// File: rtl/fwd_gate_ctl.sv
module fwd_gate_ctl
    import fwd_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int CNT_W = 4,
    parameter int CR_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  sw_mode_e         mode,
    input  logic             buf_empty,
    input  flit_kind_e       front_kind,
    input  logic [LEN_W-1:0] front_len,
    input  logic [CNT_W-1:0] buf_count,
    input  logic [CR_W-1:0]  credits,
    output logic             pop,
    output logic             start,
    output logic             locked
);
    logic locked_q;
    logic rule_ok;
    logic have_credit;

    assign have_credit = (credits != '0);

    always_comb begin
        unique case (mode)
            SW_VCT:  rule_ok = reaches(32'(credits), 32'(front_len));
            SW_WORM: rule_ok = have_credit;
            default: rule_ok = reaches(32'(buf_count), 32'(front_len))
                             && reaches(32'(credits), 32'(front_len));
        endcase
    end

    assign start = !locked_q && !buf_empty && (front_kind == FL_HEAD) && rule_ok;
    assign pop   = start || (locked_q && !buf_empty && have_credit);

    always_ff @(posedge clk) begin
        if (rst)      locked_q <= 1'b0;
        else if (pop) locked_q <= (front_kind != FL_TAIL);
    end

    assign locked = locked_q;

    // R7
    no_head_in_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_q && pop) |-> (front_kind != FL_HEAD));

    // R8
    pkt_flow_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_q && !buf_empty && (credits != '0)) |-> pop);

endmodule

// File: rtl/pkt_fwd_gate.sv
module pkt_fwd_gate
    import fwd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int LEN_W     = 4,
    parameter int BUF_DEPTH = 8,
    parameter int CRED_MAX  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sw_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_kind,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [DATA_W-1:0] out_data,
    input  logic              credit_ret
);
    localparam int CNT_W = $clog2(BUF_DEPTH+1);
    localparam int CR_W  = $clog2(CRED_MAX+1);

    logic              push, pop, start, locked;
    logic              buf_full, buf_empty;
    flit_kind_e        front_kind;
    logic [DATA_W-1:0] front_data;
    logic [CNT_W-1:0]  buf_count;
    logic [CR_W-1:0]   credits;
    sw_mode_e          mode;

    assign mode     = sw_mode_e'(sw_mode);
    assign in_ready = !buf_full;
    assign push     = in_valid && in_ready;

    fwd_flit_buf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_kind (flit_kind_e'(in_kind)),
        .push_data (in_data),
        .pop       (pop),
        .front_kind(front_kind),
        .front_data(front_data),
        .count     (buf_count),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    fwd_credit_ctr #(.CRED_MAX(CRED_MAX)) u_cred (
        .clk  (clk),
        .rst  (rst),
        .take (pop),
        .give (credit_ret),
        .avail(credits)
    );

    fwd_gate_ctl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .CR_W(CR_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .buf_empty (buf_empty),
        .front_kind(front_kind),
        .front_len (front_data[LEN_W-1:0]),
        .buf_count (buf_count),
        .credits   (credits),
        .pop       (pop),
        .start     (start),
        .locked    (locked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_kind  <= FL_BODY;
            out_data  <= '0;
        end else begin
            out_valid <= pop;
            out_kind  <= front_kind;
            out_data  <= front_data;
        end
    end

    // R2
    saf_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && (mode != SW_VCT) && (mode != SW_WORM)) |->
            ((32'(buf_count) >= 32'(front_data[LEN_W-1:0])) &&
             (32'(credits) >= 32'(front_data[LEN_W-1:0]))));

    // R3
    vct_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && (mode == SW_VCT)) |-> (32'(credits) >= 32'(front_data[LEN_W-1:0])));

    // R10
    out_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |=> out_valid);

    // R7
    tail_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && front_kind == FL_TAIL) |=> !locked);

endmodule

// File: tb/tb_pkt_fwd_gate.sv
module tb_pkt_fwd_gate;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        sw_mode = 2'b10;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [1:0]        in_kind = 2'b00;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [1:0]        out_kind;
    logic [DATA_W-1:0] out_data;
    logic              credit_ret = 1'b0;

    int checks = 0;
    int errors = 0;
    int out_n = 0;
    int tot_sent = 0;
    int tot_ret = 0;
    logic auto_ret = 1'b0;
    logic [1:0] last_kind = 2'b00;
    logic [1:0] kinds [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_fwd_gate dut (
        .clk(clk), .rst(rst), .sw_mode(sw_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
        .out_valid(out_valid), .out_kind(out_kind), .out_data(out_data),
        .credit_ret(credit_ret)
    );

    // output monitor and credit return, on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (out_n < 16) kinds[out_n] = out_kind;
                out_n++;
                tot_sent++;
                last_kind = out_kind;
            end
            if (auto_ret && tot_ret < tot_sent) begin
                credit_ret = 1'b1;
                tot_ret++;
            end else begin
                credit_ret = 1'b0;
            end
        end else begin
            credit_ret = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        auto_ret = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        out_n = 0; tot_sent = 0; tot_ret = 0;
        rst = 1'b0;
    endtask

    task automatic clear_out();
        @(posedge clk);
        out_n = 0;
    endtask

    task automatic push_flit(input logic [1:0] k, input logic [DATA_W-1:0] d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_kind  = k;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // push flits first..first+n-1 of a packet of length len
    task automatic push_pkt(input int len, input int first, input int n);
        for (int i = first; i < first + n; i++) begin
            if (i == 0)            push_flit(2'b01, {12'hA50, 4'(len)});
            else if (i == len - 1) push_flit(2'b10, DATA_W'(16'hF000 + i));
            else                   push_flit(2'b00, DATA_W'(16'hB000 + i));
        end
    endtask

    // mode, L, flits pushed first, filler length, expected flits out
    localparam int NV = 11;
    localparam logic [17:0] VECS [NV] = '{
        {2'd0, 4'd4, 4'd4, 4'd0, 4'd4},
        {2'd0, 4'd4, 4'd3, 4'd0, 4'd0},
        {2'd0, 4'd5, 4'd5, 4'd4, 4'd0},
        {2'd0, 4'd4, 4'd4, 4'd4, 4'd4},
        {2'd1, 4'd5, 4'd2, 4'd0, 4'd2},
        {2'd1, 4'd5, 4'd2, 4'd4, 4'd0},
        {2'd1, 4'd4, 4'd3, 4'd4, 4'd3},
        {2'd2, 4'd6, 4'd3, 4'd6, 4'd2},
        {2'd2, 4'd3, 4'd3, 4'd0, 4'd3},
        {2'd2, 4'd4, 4'd2, 4'd7, 4'd1},
        {2'd3, 4'd4, 4'd3, 4'd0, 4'd0}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        string tag;
        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 in_ready", int'(in_ready), 1);
        sw_mode = 2'b10;
        push_pkt(8, 0, 8);
        repeat (20) @(negedge clk);
        check("R1 full credit packet", out_n, 8);
        check("R6 tail last", int'(last_kind), 2);

        // R2 R3 R4 R5: table of start conditions
        for (int v = 0; v < NV; v++) begin
            automatic int m  = int'(VECS[v][17:16]);
            automatic int ln = int'(VECS[v][15:12]);
            automatic int k  = int'(VECS[v][11:8]);
            automatic int f  = int'(VECS[v][7:4]);
            automatic int ex = int'(VECS[v][3:0]);
            tag = (m == 1) ? "R3" : (m == 2) ? "R4" : "R2";
            do_reset();
            sw_mode = 2'b10;
            if (f > 0) push_pkt(f, 0, f);
            repeat (20) @(negedge clk);
            clear_out();
            @(negedge clk);
            sw_mode = 2'(m);
            push_pkt(ln, 0, k);
            repeat (20) @(negedge clk);
            check($sformatf("%s start vec %0d", tag, v), out_n, ex);
            auto_ret = 1'b1;
            if (k < ln) push_pkt(ln, k, ln - k);
            repeat (40) @(negedge clk);
            check($sformatf("R5 completion vec %0d", v), out_n, ln);
            check($sformatf("R6 tail kind vec %0d", v), int'(last_kind), 2);
        end

        // R9: buffer full back-pressure with no credits
        do_reset();
        sw_mode = 2'b10;
        push_pkt(8, 0, 8);
        repeat (20) @(negedge clk);
        clear_out();
        @(negedge clk);
        sw_mode = 2'b00;
        push_pkt(8, 0, 8);
        @(negedge clk);
        check("R9 in_ready when full", int'(in_ready), 0);
        check("R9 nothing sent without credit", out_n, 0);
        auto_ret = 1'b1;
        repeat (40) @(negedge clk);
        check("R9 drains after credits", out_n, 8);

        // R8: mode change inside a packet
        do_reset();
        sw_mode = 2'b10;
        push_pkt(5, 0, 3);
        repeat (10) @(negedge clk);
        check("R8 wormhole part sent", out_n, 3);
        sw_mode = 2'b00;
        push_pkt(5, 3, 1);
        repeat (10) @(negedge clk);
        check("R8 body still flows under new mode", out_n, 4);
        push_pkt(5, 4, 1);
        repeat (10) @(negedge clk);
        check("R8 tail flows", out_n, 5);

        // R7: back-to-back packets keep order
        do_reset();
        sw_mode = 2'b10;
        auto_ret = 1'b1;
        push_pkt(3, 0, 3);
        push_pkt(2, 0, 2);
        repeat (20) @(negedge clk);
        check("R7 both packets out", out_n, 5);
        check("R7 kind 0 head", int'(kinds[0]), 1);
        check("R7 kind 1 body", int'(kinds[1]), 0);
        check("R7 kind 2 tail", int'(kinds[2]), 2);
        check("R7 kind 3 head", int'(kinds[3]), 1);
        check("R7 kind 4 tail", int'(kinds[4]), 2);

        // R10: first output one cycle after the head can leave
        do_reset();
        sw_mode = 2'b10;
        @(negedge clk);
        in_valid = 1'b1; in_kind = 2'b01; in_data = {12'hA50, 4'd2};
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 not yet out", int'(out_valid), 0);
        @(negedge clk);
        check("R10 head out next cycle", int'(out_valid), 1);
        check("R10 head kind", int'(out_kind), 1);
        push_flit(2'b10, 16'hF001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule